// File: doc/BRIEF.md
# Multi-Condition Trigger Recognizer

This block watches an 18-channel sampled input bus and raises a single-cycle trigger when a programmed condition is met. Every channel carries its own 3-bit condition code: a fixed level, an edge relative to the previous strobed sample, or no constraint. The per-channel results are ANDed into one pattern condition. An event is the pattern turning true or, if selected, turning false. In duration mode an event is instead the end of a true interval whose length, counted in strobes, lies within a programmed window.

A pass counter skips the first N events and fires on event N+1. Once it fires, the block disarms and ignores all samples until software pulses `arm` again. Arming clears the pass count, the interval length, the stored previous sample and the remembered pattern state. The pattern is taken as false at arm time.

Top module: `trig_recognizer`

## Requirements
- R1: After reset, `trig_out` and `armed` are both 0.
- R2: Channel codes are 0 = don't care (6 and 7 behave the same), 1 = input low, 2 = input high, 3 = rising (previous 0, current 1), 4 = falling (previous 1, current 0), 5 = either edge. Edge codes compare against the previous strobed sample and never match on the first strobe after arm.
- R3: The pattern condition is true only when every channel matches its code. Channel i uses bits [3i+2:3i] of `cfg_cond`.
- R4: With `cfg_exit`=0 and `cfg_dur_en`=0, a strobe on which the pattern goes from false to true is an event. The pattern counts as false at arm, so all-don't-care produces an event on the first strobe.
- R5: With `cfg_exit`=1 and `cfg_dur_en`=0, a strobe on which the pattern goes from true to false is an event.
- R6: The trigger fires on event number `cfg_pass`+1. The first `cfg_pass` events are counted and skipped.
- R7: With `cfg_dur_en`=1, an event is a strobe that ends a true interval whose length L in strobes satisfies `cfg_dur_min` <= L <= `cfg_dur_max`. Intervals outside that window are not events.
- R8: The measured interval length saturates at 65535 and does not wrap.
- R9: `trig_out` is high for exactly one cycle, in the cycle after the firing strobe. At the same edge `armed` falls, and it stays low until `arm` is pulsed.
- R10: No state changes without `smp_vld`. Strobes while disarmed are ignored. A strobe in the same cycle as `arm` is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that clears state and enables recognition |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 18 | Sampled channel values |
| cfg_cond | input | 54 | Per-channel 3-bit condition codes |
| cfg_exit | input | 1 | 1 = event on pattern becoming false |
| cfg_pass | input | 10 | Number of events to skip |
| cfg_dur_en | input | 1 | Enable duration-qualified events |
| cfg_dur_min | input | 16 | Minimum interval length |
| cfg_dur_max | input | 16 | Maximum interval length |
| trig_out | output | 1 | Trigger pulse |
| armed | output | 1 | Recognizer enabled |

## Verification
The embedded assertions run on every cycle. They check that the trigger pulse never lasts more than one cycle and always follows an accepted strobe. They also check that `armed` falls only together with a trigger, and that the interval length never shrinks or drops to zero while a true interval continues. The bench scenarios cover the rest against a behavioural model: the meaning of each channel code, edges on the first strobe, AND combination, both polarities, pass counting, the duration window bounds and saturation after more than 65535 strobes.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [2:0] {
    CC_ANY  = 3'd0,
    CC_LOW  = 3'd1,
    CC_HIGH = 3'd2,
    CC_RISE = 3'd3,
    CC_FALL = 3'd4,
    CC_EDGE = 3'd5
  } chan_code_e;
endpackage

// File: rtl/tr_chan_match.sv
module tr_chan_match (
  input  logic [2:0] code,
  input  logic       cur,
  input  logic       prv,
  input  logic       prv_ok,
  output logic       hit
);
  import tr_pkg::*;

  // Per-channel condition (R2); edge codes need a stored previous sample
  always_comb begin
    unique case (code)
      CC_LOW:  hit = ~cur;
      CC_HIGH: hit = cur;
      CC_RISE: hit = prv_ok & ~prv & cur;
      CC_FALL: hit = prv_ok & prv & ~cur;
      CC_EDGE: hit = prv_ok & (prv ^ cur);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/tr_dur_qual.sv
module tr_dur_qual #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             pat,
  input  logic             cond_q,
  input  logic [DUR_W-1:0] lim_min,
  input  logic [DUR_W-1:0] lim_max,
  output logic             win_ok
);
  localparam logic [DUR_W-1:0] DUR_TOP = {DUR_W{1'b1}};

  logic [DUR_W-1:0] len_q;
  logic [DUR_W-1:0] len_d;

  always_comb begin
    len_d = len_q;
    if (clr) begin
      len_d = '0;
    end else if (step) begin
      if (pat) begin
        if (!cond_q)              len_d = {{(DUR_W-1){1'b0}}, 1'b1};
        else if (len_q != DUR_TOP) len_d = len_q + 1'b1;
      end else begin
        len_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            len_q <= '0;
    else if (clr || step)  len_q <= len_d;
  end

  // Interval ending now, length inside window (R7)
  assign win_ok = cond_q & ~pat & (len_q >= lim_min) & (len_q <= lim_max);

  assert_len_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && pat && cond_q) |=> (len_q >= $past(len_q)));

  assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && pat) |=> (len_q != '0));
endmodule

// File: rtl/tr_occ_count.sv
module tr_occ_count #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [CNT_W-1:0] pass,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Fire on occurrence pass+1 (R6)
  assign fire   = evt & (cnt_q == pass);
  assign cnt_en = clr | (evt & ~fire);

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_skip_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !fire && !clr) |=> (cnt_q != '0));
endmodule

// File: rtl/trig_recognizer.sv
module trig_recognizer #(
  parameter int NCH   = 18,
  parameter int CNT_W = 10,
  parameter int DUR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               smp_vld,
  input  logic [NCH-1:0]     smp_data,
  input  logic [3*NCH-1:0]   cfg_cond,
  input  logic               cfg_exit,
  input  logic [CNT_W-1:0]   cfg_pass,
  input  logic               cfg_dur_en,
  input  logic [DUR_W-1:0]   cfg_dur_min,
  input  logic [DUR_W-1:0]   cfg_dur_max,
  output logic               trig_out,
  output logic               armed
);
  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic           armed_q, armed_d;
  logic           pok_q, pok_d;
  logic [NCH-1:0] prev_q;
  logic           cond_q, cond_d;
  logic           trig_q;
  logic [NCH-1:0] hit;
  logic           pat;
  logic           step;
  logic           entry, leave, win_ok, evt, fire;

  // Per-channel match units (R2)
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tr_chan_match u_match (
      .code   (cfg_cond[3*i +: 3]),
      .cur    (smp_data[i]),
      .prv    (prev_q[i]),
      .prv_ok (pok_q),
      .hit    (hit[i])
    );
  end

  assign pat   = &hit;                       // R3
  assign step  = smp_vld & armed_q & ~arm;   // R10
  assign entry = pat & ~cond_q;              // R4
  assign leave = ~pat & cond_q;              // R5
  assign evt   = step & (cfg_dur_en ? win_ok : (cfg_exit ? leave : entry));

  tr_dur_qual #(.DUR_W(DUR_W)) u_dur (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (arm),
    .step    (step),
    .pat     (pat),
    .cond_q  (cond_q),
    .lim_min (cfg_dur_min),
    .lim_max (cfg_dur_max),
    .win_ok  (win_ok)
  );

  tr_occ_count #(.CNT_W(CNT_W)) u_occ (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (arm),
    .evt   (evt),
    .pass  (cfg_pass),
    .fire  (fire)
  );

  always_comb begin
    armed_d = armed_q;
    pok_d   = pok_q;
    cond_d  = cond_q;
    if (arm) begin
      armed_d = 1'b1;
      pok_d   = 1'b0;
      cond_d  = 1'b0;
    end else if (step) begin
      pok_d  = 1'b1;
      cond_d = pat;
      if (fire) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      armed_q <= 1'b0;
      pok_q   <= 1'b0;
      cond_q  <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pok_q   <= pok_d;
      cond_q  <= cond_d;
      trig_q  <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) prev_q <= '0;
    else if (step)  prev_q <= smp_data;
  end

  assign trig_out = trig_q;
  assign armed    = armed_q;

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    trig_q |=> !trig_q);

  assert_disarm_with_fire_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    trig_q |-> !armed_q);

  assert_armed_drop_cause_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(armed_q) |-> trig_q);

  assert_fire_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    trig_q |-> $past(smp_vld && armed_q && !arm));
endmodule

// File: tb/trig_recognizer_bench.sv
module trig_recognizer_bench;
  localparam int NCH = 18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              arm;
  logic              smp_vld;
  logic [NCH-1:0]    smp_data;
  logic [3*NCH-1:0]  cfg_cond;
  logic              cfg_exit;
  logic [9:0]        cfg_pass;
  logic              cfg_dur_en;
  logic [15:0]       cfg_dur_min;
  logic [15:0]       cfg_dur_max;
  logic              trig_out;
  logic              armed;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  trig_recognizer u_trig_recognizer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_vld(smp_vld), .smp_data(smp_data),
    .cfg_cond(cfg_cond), .cfg_exit(cfg_exit), .cfg_pass(cfg_pass),
    .cfg_dur_en(cfg_dur_en), .cfg_dur_min(cfg_dur_min), .cfg_dur_max(cfg_dur_max),
    .trig_out(trig_out), .armed(armed)
  );

  // Behavioural reference model
  bit            m_armed, m_havep, m_cq, m_trig;
  bit [NCH-1:0]  m_prev;
  int            m_occ, m_len;

  always @(posedge clk) begin
    bit pat, ok, ev;
    if (!rst_n) begin
      m_armed = 0; m_havep = 0; m_cq = 0; m_trig = 0; m_prev = '0; m_occ = 0; m_len = 0;
    end else begin
      m_trig = 0;
      if (arm) begin
        m_armed = 1; m_havep = 0; m_cq = 0; m_occ = 0; m_len = 0;
      end else if (smp_vld && m_armed) begin
        pat = 1;
        for (int c = 0; c < NCH; c++) begin
          case (int'(cfg_cond[3*c +: 3]))
            1: ok = !smp_data[c];
            2: ok = smp_data[c];
            3: ok = m_havep && !m_prev[c] && smp_data[c];
            4: ok = m_havep && m_prev[c] && !smp_data[c];
            5: ok = m_havep && (m_prev[c] != smp_data[c]);
            default: ok = 1;
          endcase
          if (!ok) pat = 0;
        end
        if (cfg_dur_en)
          ev = m_cq && !pat && (m_len >= int'(cfg_dur_min)) && (m_len <= int'(cfg_dur_max));
        else if (cfg_exit) ev = m_cq && !pat;
        else               ev = !m_cq && pat;
        if (pat) m_len = m_cq ? ((m_len < 65535) ? m_len + 1 : m_len) : 1;
        else     m_len = 0;
        m_cq = pat; m_prev = smp_data; m_havep = 1;
        if (ev) begin
          if (m_occ == int'(cfg_pass)) begin m_trig = 1; m_armed = 0; end
          else m_occ++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " model trig_out"}, int'(trig_out), int'(m_trig));
      chk({cur_req, " model armed"}, int'(armed), int'(m_armed));
    end
  end

  task automatic step(input bit v, input logic [NCH-1:0] d);
    smp_vld = v; smp_data = d; arm = 0;
    @(negedge clk);
    smp_vld = 0;
  endtask

  task automatic do_arm();
    arm = 1; smp_vld = 0;
    @(negedge clk);
    arm = 0;
  endtask

  task automatic set_code(input int ch, input logic [2:0] code);
    cfg_cond[3*ch +: 3] = code;
  endtask

  initial begin
    rst_n = 0; arm = 0; smp_vld = 0; smp_data = '0; cfg_cond = '0;
    cfg_exit = 0; cfg_pass = '0; cfg_dur_en = 0; cfg_dur_min = '0; cfg_dur_max = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 trig_out", int'(trig_out), 0);
    chk("R1 armed", int'(armed), 0);

    // R4 all don't care: fires on first strobe
    cur_req = "R4";
    do_arm();
    chk("R9 armed after arm", int'(armed), 1);
    step(1, 18'h2A5A5);
    chk("R4 first strobe fire", int'(trig_out), 1);
    chk("R9 disarm at fire", int'(armed), 0);
    step(1, 18'h00000);
    chk("R9 single pulse", int'(trig_out), 0);
    step(1, 18'h3FFFF);
    chk("R10 disarmed strobe", int'(trig_out), 0);

    // R10 arm and strobe same cycle: strobe ignored
    cur_req = "R10";
    arm = 1; smp_vld = 1; smp_data = '1;
    @(negedge clk);
    arm = 0; smp_vld = 0;
    chk("R10 strobe during arm", int'(trig_out), 0);
    step(0, '1);
    chk("R10 no strobe", int'(trig_out), 0);
    step(1, '1);
    chk("R10 real strobe fires", int'(trig_out), 1);

    // R2/R3 levels
    cur_req = "R3";
    cfg_cond = '0; set_code(0, 3'd2); set_code(1, 3'd1); set_code(17, 3'd2);
    do_arm();
    step(1, 18'h0);
    chk("R2 level mismatch", int'(trig_out), 0);
    step(1, 18'h1);
    chk("R3 one channel fails", int'(trig_out), 0);
    step(0, 18'h20001);
    chk("R10 data without strobe", int'(trig_out), 0);
    step(1, 18'h20001);
    chk("R3 all match", int'(trig_out), 1);

    // R2 rising
    cur_req = "R2";
    cfg_cond = '0; set_code(0, 3'd3);
    do_arm();
    step(1, 18'h1);
    chk("R2 rise first strobe", int'(trig_out), 0);
    step(1, 18'h1);
    chk("R2 rise steady", int'(trig_out), 0);
    step(1, 18'h0);
    chk("R2 rise low", int'(trig_out), 0);
    step(1, 18'h1);
    chk("R2 rise edge", int'(trig_out), 1);

    // R2 falling
    cfg_cond = '0; set_code(5, 3'd4);
    do_arm();
    step(1, 18'h0);
    chk("R2 fall first", int'(trig_out), 0);
    step(1, 18'h20);
    chk("R2 fall high", int'(trig_out), 0);
    step(1, 18'h0);
    chk("R2 fall edge", int'(trig_out), 1);

    // R2 either edge, code 7 as don't care
    cfg_cond = '0; set_code(2, 3'd5); set_code(3, 3'd7);
    do_arm();
    step(1, 18'h0);
    chk("R2 either first", int'(trig_out), 0);
    step(1, 18'h8);
    chk("R2 either steady", int'(trig_out), 0);
    step(1, 18'hC);
    chk("R2 either edge", int'(trig_out), 1);

    // R5 exit polarity
    cur_req = "R5";
    cfg_cond = '0; set_code(0, 3'd2); cfg_exit = 1;
    do_arm();
    step(1, 18'h0);
    chk("R5 false at arm", int'(trig_out), 0);
    step(1, 18'h1);
    chk("R5 entry ignored", int'(trig_out), 0);
    step(1, 18'h1);
    chk("R5 stays true", int'(trig_out), 0);
    step(1, 18'h0);
    chk("R5 exit fires", int'(trig_out), 1);
    cfg_exit = 0;

    // R6 pass count 3
    cur_req = "R6";
    cfg_pass = 10'd3;
    do_arm();
    for (int k = 1; k <= 4; k++) begin
      step(1, 18'h1);
      chk($sformatf("R6 occurrence %0d", k), int'(trig_out), (k == 4) ? 1 : 0);
      step(1, 18'h0);
    end
    cfg_pass = '0;

    // R7 duration window 3..5
    cur_req = "R7";
    cfg_dur_en = 1; cfg_dur_min = 16'd3; cfg_dur_max = 16'd5;
    do_arm();
    repeat (2) step(1, 18'h1);
    step(1, 18'h0);
    chk("R7 short interval", int'(trig_out), 0);
    repeat (6) step(1, 18'h1);
    step(1, 18'h0);
    chk("R7 long interval", int'(trig_out), 0);
    repeat (4) step(1, 18'h1);
    step(1, 18'h0);
    chk("R7 in window", int'(trig_out), 1);
    do_arm();
    repeat (3) step(1, 18'h1);
    step(1, 18'h0);
    chk("R7 min bound", int'(trig_out), 1);
    do_arm();
    repeat (5) step(1, 18'h1);
    step(1, 18'h0);
    chk("R7 max bound", int'(trig_out), 1);

    // R8 saturation
    cur_req = "R8";
    cfg_dur_min = 16'hFFFF; cfg_dur_max = 16'hFFFF;
    do_arm();
    repeat (70000) step(1, 18'h1);
    step(1, 18'h0);
    chk("R8 saturated length", int'(trig_out), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog %s act=hung exp=done", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule